// File: doc/BRIEF.md
# Sector Erase Command Sequencer

This block is the command front end of a parallel NOR-style flash that handles sector erase. It watches completed write bus cycles. Each cycle is given as a one-clock `wr_en` pulse with its address and data. The block recognises the six-cycle sector erase sequence, which is two unlock writes, a set-up write, two more unlock writes and then a sector write. It collects the chosen sectors into a selection bitmap. After the sequence an acceptance window opens, and more sector writes may be added while it is open. When the window runs out, a simulated erase starts. The erase is a fixed run of timer ticks.

Time is counted in pulses on the `tick` input, so the window length and the erase length are tick-count parameters. The integrating system sets them to match its own timebase. Once the erase is running, only the suspend command acts. A suspend freezes the erase, and resuming is not handled by this block. A reset abandons everything at any point.

Top module: `sector_erase_ctrl`

## Requirements
- R1: After reset, every output is 0: window closed, not erasing, not suspended, status flag 0, done 0, selection 0.
- R2: The write cycles (addr[10:0]=0x555, data 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), then (any address, data 0x30), open the window. The sector number addr[15:13] sets its bit in `sel_o`, and `timer_flag_o` stays 0.
- R3: A write in any of the first five positions that does not match its expected address and data sends the machine back to read mode. The rest of that broken sequence then opens no window.
- R4: While the window is open, a write with data 0x30 ORs the bit for its sector into `sel_o`, whatever the order of sectors. It also restarts the window count.
- R5: If WIN_TICKS tick pulses pass with no accepted sector write, the window closes and the erase starts: `erasing_o`=1 and `timer_flag_o`=1. After WIN_TICKS-1 pulses the window is still open.
- R6: A write during the window whose data is neither 0x30 nor 0xB0 closes the window, clears `sel_o`, and returns to read mode. No erase follows.
- R7: A suspend write (data 0xB0) during the window has no effect. The window and the selection are kept, and the erase still starts on time.
- R8: While erasing, every write other than 0xB0 is ignored. After ERASE_TICKS tick pulses, `done_o` pulses for one clock, `erasing_o` falls and `sel_o` clears.
- R9: A 0xB0 write while erasing enters the suspended state. In that state `suspended_o`=1, `timer_flag_o`=1 and `sel_o` is kept. Ticks and writes there have no effect.
- R10: Reset during an erase or a suspend aborts it at once and clears the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | One-clock pulse for each completed write cycle |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data |
| tick | input | 1 | Timebase pulse |
| window_o | output | 1 | Acceptance window open |
| erasing_o | output | 1 | Erase running |
| suspended_o | output | 1 | Erase suspended |
| timer_flag_o | output | 1 | 0 while the window is open, 1 once erase has begun |
| done_o | output | 1 | One-clock pulse when the erase completes |
| sel_o | output | 2**SECT_BITS | Sector selection bitmap |

## Verification
The hardest case to reach is an extra sector write that lands one tick before the window would close. That write must restart the count, so it proves the restart rather than only the first expiry. The bench shortens the window to a few ticks and uses exact tick counts. It lets the window run to WIN_TICKS-1 pulses, adds a sector, runs the same number of pulses again, and confirms the window is still open. Freezing a suspended erase is checked the same way: the bench issues far more ticks than the erase length and then observes that no completion pulse appears.

// File: rtl/erase_pkg.sv
package erase_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UL1,
        ST_UL2,
        ST_SETUP,
        ST_UL3,
        ST_UL4,
        ST_WINDOW,
        ST_ERASE,
        ST_SUSP
    } seq_state_e;

    localparam logic [10:0] KEY_ADDR_A = 11'h555;
    localparam logic [10:0] KEY_ADDR_B = 11'h2AA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CMD_ARM    = 8'h80;
    localparam logic [7:0]  CMD_SECTOR = 8'h30;
    localparam logic [7:0]  CMD_HOLD   = 8'hB0;

endpackage

// File: rtl/cmd_match.sv
module cmd_match
    import erase_pkg::*;
#(
    parameter int CMD_AW = 11
) (
    input  logic [CMD_AW-1:0] addr_lo,
    input  logic [7:0]        data,
    output logic              is_key_a,
    output logic              is_key_b,
    output logic              is_arm,
    output logic              is_sector,
    output logic              is_hold
);
    always_comb begin
        is_key_a  = (addr_lo == CMD_AW'(KEY_ADDR_A)) && (data == KEY_DATA_A);
        is_key_b  = (addr_lo == CMD_AW'(KEY_ADDR_B)) && (data == KEY_DATA_B);
        is_arm    = (addr_lo == CMD_AW'(KEY_ADDR_A)) && (data == CMD_ARM);
        is_sector = (data == CMD_SECTOR);
        is_hold   = (data == CMD_HOLD);
    end
endmodule

// File: rtl/sector_decode.sv
module sector_decode #(
    parameter int SECT_BITS = 3,
    localparam int NSEC = 1 << SECT_BITS
) (
    input  logic [SECT_BITS-1:0] sector,
    output logic [NSEC-1:0]      onehot
);
    for (genvar i = 0; i < NSEC; i++) begin : g_bit
        assign onehot[i] = (sector == SECT_BITS'(i));
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        hit = step && (cnt_q == limit - W'(1));
        if (clear)     cnt_d = '0;
        else if (step) cnt_d = cnt_q + W'(1);
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sector_erase_ctrl.sv
module sector_erase_ctrl
    import erase_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SECT_BITS   = 3,
    parameter int CMD_AW      = 11,
    parameter int WIN_TICKS   = 50,
    parameter int ERASE_TICKS = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [7:0]                wr_data,
    input  logic                      tick,
    output logic                      window_o,
    output logic                      erasing_o,
    output logic                      suspended_o,
    output logic                      timer_flag_o,
    output logic                      done_o,
    output logic [(1<<SECT_BITS)-1:0] sel_o
);
    localparam int NSEC  = 1 << SECT_BITS;
    localparam int MAXT  = (WIN_TICKS > ERASE_TICKS) ? WIN_TICKS : ERASE_TICKS;
    localparam int TMR_W = $clog2(MAXT + 1);

    typedef struct packed {
        seq_state_e      state;
        logic [NSEC-1:0] sel;
        logic            done;
    } regs_t;

    regs_t r_d, r_q;

    logic key_a, key_b, arm, sect_cmd, hold_cmd;
    logic [NSEC-1:0] sect_bit;
    logic tmr_clr, tmr_step, tmr_hit;
    logic [TMR_W-1:0] tmr_limit;

    cmd_match #(.CMD_AW(CMD_AW)) u_match (
        .addr_lo  (wr_addr[CMD_AW-1:0]),
        .data     (wr_data),
        .is_key_a (key_a),
        .is_key_b (key_b),
        .is_arm   (arm),
        .is_sector(sect_cmd),
        .is_hold  (hold_cmd)
    );

    sector_decode #(.SECT_BITS(SECT_BITS)) u_dec (
        .sector(wr_addr[ADDR_W-1 -: SECT_BITS]),
        .onehot(sect_bit)
    );

    assign tmr_step  = tick && ((r_q.state == ST_WINDOW) || (r_q.state == ST_ERASE));
    assign tmr_limit = (r_q.state == ST_WINDOW) ? TMR_W'(WIN_TICKS) : TMR_W'(ERASE_TICKS);

    tick_counter #(.W(TMR_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(tmr_clr),
        .step (tmr_step),
        .limit(tmr_limit),
        .hit  (tmr_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_clr  = 1'b1;
        unique case (r_q.state)
            ST_READ: begin
                if (wr_en && key_a) r_d.state = ST_UL1;
            end
            ST_UL1: begin
                if (wr_en) r_d.state = key_b ? ST_UL2 : ST_READ;
            end
            ST_UL2: begin
                if (wr_en) r_d.state = arm ? ST_SETUP : ST_READ;
            end
            ST_SETUP: begin
                if (wr_en) r_d.state = key_a ? ST_UL3 : ST_READ;
            end
            ST_UL3: begin
                if (wr_en) r_d.state = key_b ? ST_UL4 : ST_READ;
            end
            ST_UL4: begin
                if (wr_en) begin
                    if (sect_cmd) begin
                        r_d.state = ST_WINDOW;
                        r_d.sel   = sect_bit;
                    end else begin
                        r_d.state = ST_READ;
                    end
                end
            end
            ST_WINDOW: begin
                if (wr_en && sect_cmd) begin
                    r_d.sel = r_q.sel | sect_bit;
                end else if (wr_en && !hold_cmd) begin
                    r_d.state = ST_READ;
                    r_d.sel   = '0;
                end else if (tmr_hit) begin
                    r_d.state = ST_ERASE;
                end else begin
                    tmr_clr = 1'b0;
                end
            end
            ST_ERASE: begin
                if (wr_en && hold_cmd) begin
                    r_d.state = ST_SUSP;
                    tmr_clr   = 1'b0;
                end else if (tmr_hit) begin
                    r_d.state = ST_READ;
                    r_d.sel   = '0;
                    r_d.done  = 1'b1;
                end else begin
                    tmr_clr = 1'b0;
                end
            end
            ST_SUSP: begin
                tmr_clr = 1'b0;
            end
            default: begin
                r_d.state = ST_READ;
                r_d.sel   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_READ;
            r_q.sel   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign window_o     = (r_q.state == ST_WINDOW);
    assign erasing_o    = (r_q.state == ST_ERASE);
    assign suspended_o  = (r_q.state == ST_SUSP);
    assign timer_flag_o = (r_q.state == ST_ERASE) || (r_q.state == ST_SUSP);
    assign done_o       = r_q.done;
    assign sel_o        = r_q.sel;

endmodule

// File: rtl/sector_erase_chk.sv
module sector_erase_chk #(
    parameter int SEL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             window_o,
    input logic             erasing_o,
    input logic             suspended_o,
    input logic             timer_flag_o,
    input logic             done_o,
    input logic [SEL_W-1:0] sel_o
);
    // R2: status flag reads 0 while sectors are still being accepted
    a_r2_flag_low_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        window_o |-> !timer_flag_o);

    // R4: an open window only ever adds sectors
    a_r4_sel_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (window_o && $past(window_o)) |-> ((sel_o & $past(sel_o)) == $past(sel_o)));

    // R5: erase begins only out of an open window
    a_r5_erase_from_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erasing_o) |-> $past(window_o));

    // R5: an erase always has at least one sector
    a_r5_erase_has_sector: assert property (@(posedge clk) disable iff (!rst_n)
        erasing_o |-> (sel_o != '0));

    // R8: completion leaves read mode with nothing selected
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sel_o == '0) && !erasing_o && !window_o && $past(erasing_o));

    // R9: suspended state holds selection and never completes
    a_r9_suspend_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended_o && $past(suspended_o)) |-> ($stable(sel_o) && !done_o));

    // R8: status modes are exclusive
    a_r8_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({window_o, erasing_o, suspended_o}));
endmodule

bind sector_erase_ctrl sector_erase_chk #(.SEL_W(1 << SECT_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .window_o    (window_o),
    .erasing_o   (erasing_o),
    .suspended_o (suspended_o),
    .timer_flag_o(timer_flag_o),
    .done_o      (done_o),
    .sel_o       (sel_o)
);

// File: tb/sector_erase_ctrl_test.sv
`timescale 1ns/1ps
module sector_erase_ctrl_test;
    localparam int ADDR_W = 16;
    localparam int SB     = 3;
    localparam int WIN    = 4;
    localparam int ERS    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              tick = 1'b0;
    logic window_o, erasing_o, suspended_o, timer_flag_o, done_o;
    logic [7:0] sel_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sector_erase_ctrl #(
        .ADDR_W(ADDR_W), .SECT_BITS(SB), .CMD_AW(11),
        .WIN_TICKS(WIN), .ERASE_TICKS(ERS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .window_o(window_o),
        .erasing_o(erasing_o), .suspended_o(suspended_o),
        .timer_flag_o(timer_flag_o), .done_o(done_o), .sel_o(sel_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    function automatic logic [ADDR_W-1:0] sa(input int s);
        return {3'(s), 13'h0AB};
    endfunction

    task automatic seq(input int s);
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
        wr(16'h0555, 8'h80);
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
        wr(sa(s), 8'h30);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 window", window_o, 0);
        chk("R1 erasing", erasing_o, 0);
        chk("R1 suspended", suspended_o, 0);
        chk("R1 flag", timer_flag_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 sel", sel_o, 0);
    endtask

    task automatic t_basic();
        do_reset();
        seq(5);
        chk("R2 window open", window_o, 1);
        chk("R2 sel", sel_o, 8'h20);
        chk("R2 flag", timer_flag_o, 0);
        ticks(WIN - 1);
        chk("R5 still open", window_o, 1);
        ticks(1);
        chk("R5 erasing", erasing_o, 1);
        chk("R5 flag", timer_flag_o, 1);
        wr(16'h0555, 8'hAA);
        wr(16'h0000, 8'hF0);
        wr(sa(1), 8'h30);
        chk("R8 ignored erasing", erasing_o, 1);
        chk("R8 ignored sel", sel_o, 8'h20);
        ticks(ERS - 1);
        chk("R8 not yet done", erasing_o, 1);
        ticks(1);
        chk("R8 done pulse", done_o, 1);
        chk("R8 erasing low", erasing_o, 0);
        chk("R8 sel cleared", sel_o, 0);
        @(negedge clk);
        chk("R8 done one clock", done_o, 0);
    endtask

    task automatic t_multi();
        do_reset();
        seq(6);
        ticks(WIN - 1);
        wr(sa(1), 8'h30);
        ticks(WIN - 1);
        chk("R4 restart window", window_o, 1);
        chk("R4 sel two", sel_o, 8'h42);
        wr(sa(3), 8'h30);
        wr(sa(0), 8'h30);
        chk("R4 sel any order", sel_o, 8'h4B);
        ticks(WIN);
        chk("R4 erase after last", erasing_o, 1);
        chk("R4 sel kept", sel_o, 8'h4B);
    endtask

    task automatic t_abort();
        do_reset();
        seq(2);
        wr(16'h0555, 8'hF0);
        chk("R6 window closed", window_o, 0);
        chk("R6 sel cleared", sel_o, 0);
        ticks(WIN + 3);
        chk("R6 no erase", erasing_o, 0);
    endtask

    task automatic t_susp();
        do_reset();
        seq(1);
        ticks(1);
        wr(16'h0000, 8'hB0);
        chk("R7 window kept", window_o, 1);
        chk("R7 sel kept", sel_o, 8'h02);
        ticks(WIN - 1);
        chk("R7 erase on time", erasing_o, 1);
        ticks(2);
        wr(16'h1234, 8'hB0);
        chk("R9 suspended", suspended_o, 1);
        chk("R9 not erasing", erasing_o, 0);
        chk("R9 flag", timer_flag_o, 1);
        ticks(ERS * 3);
        wr(16'h0555, 8'hAA);
        chk("R9 still suspended", suspended_o, 1);
        chk("R9 no done", done_o, 0);
        chk("R9 sel kept", sel_o, 8'h02);
        do_reset();
        chk("R10 suspend aborted", suspended_o, 0);
        chk("R10 sel cleared", sel_o, 0);
    endtask

    task automatic t_mismatch();
        do_reset();
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
        wr(16'h0555, 8'h80);
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h56);
        wr(sa(4), 8'h30);
        chk("R3 bad cycle5", window_o, 0);
        wr(16'h0555, 8'hAB);
        wr(16'h02AA, 8'h55);
        wr(16'h0555, 8'h80);
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
        wr(sa(4), 8'h30);
        chk("R3 bad cycle1", window_o, 0);
        chk("R3 sel empty", sel_o, 0);
        seq(4);
        chk("R2 after mismatch", sel_o, 8'h10);
    endtask

    task automatic t_reset_mid();
        do_reset();
        seq(7);
        ticks(WIN + 2);
        chk("R10 erasing before", erasing_o, 1);
        do_reset();
        chk("R10 erase aborted", erasing_o, 0);
        chk("R10 sel zero", sel_o, 0);
        ticks(ERS + 2);
        chk("R10 no done after", done_o, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_multi();
        t_abort();
        t_susp();
        t_mismatch();
        t_reset_mid();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule